// File: doc/BRIEF.md
# Program-Verify Pre-Distortion Calculator

This block runs once per cell ahead of a page program. The data that will later land in a cell's interfering neighbours is already known at that point. The block therefore predicts how far capacitive coupling from those neighbours will raise the victim's threshold voltage. It then lowers the victim's program-verify target by that amount, so that the level settles in the right place once the neighbours are written.

Each cell arrives with the victim's target state, the target states of its neighbours, and a per-cell grid-selection bit. A shared configuration supplies:
- a four-entry table of expected post-program levels,
- the erased-state mean,
- one coupling coefficient per neighbour.

The block returns a quantized verify code on a coarse 16-step or 32-step grid. It also returns a flag that marks cells which stay erased and so get no program pulses. The computation is a three-stage pipeline behind a valid/ready handshake and accepts one cell per cycle. The configuration inputs are assumed to stay static while cells are in flight.

Top module: `pgm_predistort`

## Requirements
- R1: A cell whose victim state is 0 (erased) yields o_noprog = 1 and o_code = 0, whatever its neighbours hold; any other victim state yields o_noprog = 0.
- R2: Levels are unsigned with 8 fraction bits (12-bit fields). Coefficients are unsigned with 10 fraction bits (10-bit fields); neighbour j occupies bits [10j+9:10j] of i_coef and bits [2j+1:2j] of i_nbr_state. The predicted shift I is the sum over neighbours of coef_j * (table[s_j] - mean), where table entry k sits at bits [12k+11:12k]. Each term is rounded toward minus infinity to one level LSB before the sum.
- R3: A neighbour whose target state is 0 adds exactly zero to I, whatever table entry 0 holds.
- R4: The adjusted target is nominal[v] - I. The nominal verify levels for states 1, 2 and 3 default to 666, 819 and 1006 (2.6, 3.2 and 3.93 units).
- R5: With i_fine = 1 the code is floor(target/128) on a 32-step grid. With i_fine = 0 it is floor(target/256) on a 16-step grid.
- R6: A negative target quantizes to 0. A target above the grid saturates to 31 (fine) or 15 (coarse).
- R7: The code never falls below the quantized level of the next lower state on the same grid. That level is the erased mean for state 1, nominal[1] for state 2 and nominal[2] for state 3.
- R8: i_ready is high whenever the output register is empty or is being consumed. An accepted cell appears on the output on the third rising edge after acceptance. Results leave in order, one per cycle when o_ready stays high.
- R9: While o_valid is high and o_ready is low, o_code and o_noprog hold their values.
- R10: After reset, o_valid is 0 and i_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_valid | input | 1 | Cell offered |
| i_ready | output | 1 | Cell accepted this cycle when high together with i_valid |
| i_state | input | 2 | Victim target state |
| i_nbr_state | input | 6 | Target states of the three interfering neighbours |
| i_fine | input | 1 | 1 selects the 32-step grid, 0 the 16-step grid |
| i_exp_lvl | input | 48 | Expected post-program level for each of the four states |
| i_erase_mean | input | 12 | Erased-state mean level |
| i_coef | input | 30 | Coupling coefficient for each neighbour |
| o_valid | output | 1 | Result present |
| o_ready | input | 1 | Downstream takes the result |
| o_code | output | 5 | Quantized verify code |
| o_noprog | output | 1 | Cell stays erased; no program pulses |

## Verification
The two events that can coincide are release of a stalled result and acceptance of a new cell. When o_ready rises while a cell is waiting at the input, the output register takes the next result on the same edge that a new cell enters the first stage. The bench fills the pipe with o_ready low and holds a fourth cell at the input. It then raises o_ready and judges the outcome in three parts:
- the stalled result held steady,
- i_ready stayed low during the stall,
- the following three results emerge in order on consecutive cycles, each with its own expected code.

// File: rtl/pdc_pkg.sv
// Shared constants for the pre-distortion calculator.
// Assumes 2 bits per cell and normalized levels scaled by 256.
package pdc_pkg;
    localparam int LVL_W_DEF  = 12;   // level width, 8 fraction bits
    localparam int COEF_W_DEF = 10;   // coefficient width, all fraction
    localparam int N_NBR_DEF  = 3;    // interfering neighbours per cell
    localparam int CODE_W_DEF = 5;    // width of the fine-grid code
    localparam int ST_W       = 2;    // state width
    localparam int N_ST       = 4;    // number of states
    localparam int VFY1_DEF   = 666;  // 2.6 units
    localparam int VFY2_DEF   = 819;  // 3.2 units
    localparam int VFY3_DEF   = 1006; // 3.93 units
endpackage

// File: rtl/pdc_term.sv
// One neighbour's coupling contribution: coef * (level - mean), floored to
// one level LSB. Assumes the coefficient is an unsigned pure fraction.
// An erased neighbour contributes zero.
module pdc_term #(
    parameter int LVL_W  = 12,
    parameter int COEF_W = 10,
    parameter int TERM_W = LVL_W + 2
) (
    input  logic [LVL_W-1:0]         lvl,
    input  logic [LVL_W-1:0]         mean,
    input  logic [COEF_W-1:0]        coef,
    input  logic                     erased,
    output logic signed [TERM_W-1:0] term
);
    localparam int PROD_W = LVL_W + COEF_W + 2;

    logic signed [LVL_W:0]    diff;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;

    // Signed level excursion, product, and floor back to level units
    always_comb begin
        diff   = $signed({1'b0, lvl}) - $signed({1'b0, mean});
        prod   = PROD_W'(diff) * PROD_W'($signed({1'b0, coef}));
        scaled = prod >>> COEF_W;
        term   = erased ? '0 : TERM_W'(scaled);
    end
endmodule

// File: rtl/pdc_quant.sv
// Maps a signed verify target onto the 16- or 32-step grid.
// Negative targets go to 0, oversize targets saturate, and the result is
// held at or above the quantized lower-state level.
// Assumes LVL_W > CODE_W.
module pdc_quant #(
    parameter int LVL_W  = 12,
    parameter int TGT_W  = 18,
    parameter int CODE_W = 5
) (
    input  logic signed [TGT_W-1:0] target,
    input  logic [LVL_W-1:0]        floor_lvl,
    input  logic                    fine,
    output logic [CODE_W-1:0]       code
);
    localparam int SH_F  = LVL_W - CODE_W;
    localparam int SH_C  = SH_F + 1;
    localparam int MAX_F = (2 ** CODE_W) - 1;
    localparam int MAX_C = (2 ** (CODE_W - 1)) - 1;

    logic signed [TGT_W-1:0] q;
    logic signed [TGT_W-1:0] q_max;
    logic [LVL_W-1:0]        raw_w;
    logic [LVL_W-1:0]        lb_w;

    // Grid step, saturation and lower-state floor
    always_comb begin
        q     = fine ? (target >>> SH_F) : (target >>> SH_C);
        q_max = fine ? TGT_W'(MAX_F) : TGT_W'(MAX_C);
        lb_w  = fine ? (floor_lvl >> SH_F) : (floor_lvl >> SH_C);
        if (q < 0)
            raw_w = '0;
        else if (q > q_max)
            raw_w = LVL_W'(q_max);
        else
            raw_w = LVL_W'(q);
        code = CODE_W'((raw_w < lb_w) ? lb_w : raw_w);
    end
endmodule

// File: rtl/pgm_predistort.sv
// Pre-distortion calculator top. Three stages:
//   S1 looks up the neighbours' expected levels,
//   S2 forms the coupling terms,
//   S3 sums, subtracts from nominal and quantizes.
// One global stall holds all stages while the output waits.
// Assumes the configuration inputs are static while cells are in flight.
module pgm_predistort #(
    parameter int LVL_W  = pdc_pkg::LVL_W_DEF,
    parameter int COEF_W = pdc_pkg::COEF_W_DEF,
    parameter int N_NBR  = pdc_pkg::N_NBR_DEF,
    parameter int CODE_W = pdc_pkg::CODE_W_DEF,
    parameter int VFY1   = pdc_pkg::VFY1_DEF,
    parameter int VFY2   = pdc_pkg::VFY2_DEF,
    parameter int VFY3   = pdc_pkg::VFY3_DEF
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              i_valid,
    output logic                              i_ready,
    input  logic [pdc_pkg::ST_W-1:0]          i_state,
    input  logic [N_NBR*pdc_pkg::ST_W-1:0]    i_nbr_state,
    input  logic                              i_fine,
    input  logic [pdc_pkg::N_ST*LVL_W-1:0]    i_exp_lvl,
    input  logic [LVL_W-1:0]                  i_erase_mean,
    input  logic [N_NBR*COEF_W-1:0]           i_coef,
    output logic                              o_valid,
    input  logic                              o_ready,
    output logic [CODE_W-1:0]                 o_code,
    output logic                              o_noprog
);
    localparam int ST_W   = pdc_pkg::ST_W;
    localparam int TERM_W = LVL_W + 2;
    localparam int SUM_W  = TERM_W + $clog2(N_NBR) + 1;
    localparam int TGT_W  = SUM_W + 1;

    logic adv;
    assign adv     = !o_valid || o_ready;
    assign i_ready = adv;

    // Stage 1 state
    logic                    s1_vld, s1_fine;
    logic [ST_W-1:0]         s1_state;
    logic [LVL_W-1:0]        s1_lvl    [N_NBR];
    logic                    s1_erased [N_NBR];
    logic [LVL_W-1:0]        lvl_sel   [N_NBR];
    logic [ST_W-1:0]         nbr_st    [N_NBR];

    // Stage 2 state
    logic                    s2_vld, s2_fine;
    logic [ST_W-1:0]         s2_state;
    logic signed [TERM_W-1:0] term_w  [N_NBR];
    logic signed [TERM_W-1:0] s2_term [N_NBR];

    // Stage 3 combinational
    logic signed [SUM_W-1:0] interf;
    logic [LVL_W-1:0]        nominal, floor_lvl;
    logic signed [TGT_W-1:0] target;
    logic [CODE_W-1:0]       code_w;
    logic                    o_fine;

    // Per-neighbour table lookup and coupling term
    for (genvar g = 0; g < N_NBR; g++) begin : g_nbr
        assign nbr_st[g]  = i_nbr_state[g*ST_W +: ST_W];
        assign lvl_sel[g] = i_exp_lvl[nbr_st[g]*LVL_W +: LVL_W];
        pdc_term #(.LVL_W(LVL_W), .COEF_W(COEF_W), .TERM_W(TERM_W)) u_term (
            .lvl    (s1_lvl[g]),
            .mean   (i_erase_mean),
            .coef   (i_coef[g*COEF_W +: COEF_W]),
            .erased (s1_erased[g]),
            .term   (term_w[g])
        );
    end

    // S1: capture cell and neighbour levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_fine  <= 1'b0;
            s1_state <= '0;
            for (int k = 0; k < N_NBR; k++) begin
                s1_lvl[k]    <= '0;
                s1_erased[k] <= 1'b1;
            end
        end else if (adv) begin
            s1_vld   <= i_valid;
            s1_fine  <= i_fine;
            s1_state <= i_state;
            for (int k = 0; k < N_NBR; k++) begin
                s1_lvl[k]    <= lvl_sel[k];
                s1_erased[k] <= (nbr_st[k] == '0);
            end
        end
    end

    // S2: capture coupling terms
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld   <= 1'b0;
            s2_fine  <= 1'b0;
            s2_state <= '0;
            for (int k = 0; k < N_NBR; k++) s2_term[k] <= '0;
        end else if (adv) begin
            s2_vld   <= s1_vld;
            s2_fine  <= s1_fine;
            s2_state <= s1_state;
            for (int k = 0; k < N_NBR; k++) s2_term[k] <= term_w[k];
        end
    end

    // S3 combinational: total shift, nominal and floor per victim state
    always_comb begin
        interf = '0;
        for (int k = 0; k < N_NBR; k++) interf = interf + SUM_W'(s2_term[k]);
        case (s2_state)
            2'd1:    begin nominal = LVL_W'(VFY1); floor_lvl = i_erase_mean;   end
            2'd2:    begin nominal = LVL_W'(VFY2); floor_lvl = LVL_W'(VFY1);   end
            2'd3:    begin nominal = LVL_W'(VFY3); floor_lvl = LVL_W'(VFY2);   end
            default: begin nominal = '0;           floor_lvl = '0;             end
        endcase
        target = $signed({{(TGT_W-LVL_W){1'b0}}, nominal}) - TGT_W'(interf);
    end

    pdc_quant #(.LVL_W(LVL_W), .TGT_W(TGT_W), .CODE_W(CODE_W)) u_quant (
        .target    (target),
        .floor_lvl (floor_lvl),
        .fine      (s2_fine),
        .code      (code_w)
    );

    // S3: output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid  <= 1'b0;
            o_code   <= '0;
            o_noprog <= 1'b0;
            o_fine   <= 1'b0;
        end else if (adv) begin
            o_valid  <= s2_vld;
            o_noprog <= (s2_state == '0);
            o_code   <= (s2_state == '0) ? '0 : code_w;
            o_fine   <= s2_fine;
        end
    end

    // R9: stalled result holds
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid && !o_ready |=> o_valid && $stable(o_code) && $stable(o_noprog));

    // R1: an erased cell carries a zero code
    assert_noprog_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid && o_noprog |-> o_code == '0);

    // R5: the coarse grid stays within 16 steps
    assert_coarse_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid && !o_fine |-> o_code < CODE_W'(2 ** (CODE_W - 1)));

    // R8: a valid second stage reaches the output when the pipe advances
    assert_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s2_vld && adv |=> o_valid);
endmodule

// File: tb/pgm_predistort_bench.sv
module pgm_predistort_bench;
    logic        clk = 1'b0;
    logic        rst_n, i_valid, i_ready, i_fine, o_valid, o_ready, o_noprog;
    logic [1:0]  i_state;
    logic [5:0]  i_nbr_state;
    logic [47:0] i_exp_lvl;
    logic [11:0] i_erase_mean;
    logic [29:0] i_coef;
    logic [4:0]  o_code;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    pgm_predistort u_pgm_predistort (
        .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_ready(i_ready),
        .i_state(i_state), .i_nbr_state(i_nbr_state), .i_fine(i_fine),
        .i_exp_lvl(i_exp_lvl), .i_erase_mean(i_erase_mean), .i_coef(i_coef),
        .o_valid(o_valid), .o_ready(o_ready), .o_code(o_code), .o_noprog(o_noprog)
    );

    // Vector fields: {victim, n2, n1, n0, fine, code, noprog}.
    // Config: table {1100, 860, 700, 4000}, mean 358, coefs n0 = 82, n1 = n2 = 5.
    localparam logic [14:0] VEC [8] = '{
        {2'd1, 2'd3, 2'd3, 2'd3, 1'b1, 5'd4, 1'b0},  // shift 65, target 601
        {2'd1, 2'd3, 2'd3, 2'd3, 1'b0, 5'd2, 1'b0},
        {2'd2, 2'd0, 2'd0, 2'd0, 1'b1, 5'd6, 1'b0},  // erased neighbours, shift 0
        {2'd2, 2'd0, 2'd0, 2'd3, 1'b1, 5'd5, 1'b0},  // 760 -> 5
        {2'd3, 2'd3, 2'd3, 2'd3, 1'b1, 5'd7, 1'b0},  // 941 -> 7
        {2'd3, 2'd3, 2'd3, 2'd3, 1'b0, 5'd3, 1'b0},
        {2'd0, 2'd3, 2'd3, 2'd3, 1'b1, 5'd0, 1'b1},  // erased victim
        {2'd2, 2'd1, 2'd1, 2'd2, 1'b0, 5'd3, 1'b0}   // shift 42, 777 -> 3
    };

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(int e0, int e1, int e2, int e3, int mean, int c0, int c1, int c2);
        i_exp_lvl    = {12'(e3), 12'(e2), 12'(e1), 12'(e0)};
        i_erase_mean = 12'(mean);
        i_coef       = {10'(c2), 10'(c1), 10'(c0)};
    endtask

    task automatic drive(logic [1:0] v, logic [1:0] n0, logic [1:0] n1, logic [1:0] n2, logic f);
        i_state     = v;
        i_nbr_state = {n2, n1, n0};
        i_fine      = f;
    endtask

    // Offer one cell, then check the result three edges after acceptance
    task automatic run_one(logic [1:0] v, logic [1:0] n0, logic [1:0] n1, logic [1:0] n2,
                           logic f, int ecode, int enp, string req);
        @(negedge clk);
        drive(v, n0, n1, n2, f);
        i_valid = 1'b1;
        @(negedge clk);
        i_valid = 1'b0;
        chk({req, " R8 latency"}, int'(o_valid), 0);
        @(negedge clk);
        @(negedge clk);
        chk({req, " R8 valid"}, int'(o_valid), 1);
        chk({req, " code"}, int'(o_code), ecode);
        chk({req, " R1 noprog"}, int'(o_noprog), enp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R8 watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        i_valid = 1'b0;
        o_ready = 1'b1;
        drive(2'd0, 2'd0, 2'd0, 2'd0, 1'b0);
        set_cfg(4000, 700, 860, 1100, 358, 82, 5, 5);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 valid after reset", int'(o_valid), 0);
        chk("R10 ready after reset", int'(i_ready), 1);

        // Table walk: R2 R3 R4 R5 R7
        for (int i = 0; i < 8; i++) begin
            run_one(VEC[i][14:13], VEC[i][8:7], VEC[i][10:9], VEC[i][12:11],
                    VEC[i][6], int'(VEC[i][5:1]), int'(VEC[i][0]),
                    $sformatf("R2 R3 R4 R5 vec%0d", i));
        end

        // R7: large shift clamps at the state-2 floor (819>>7 = 6)
        set_cfg(4000, 700, 860, 1100, 358, 1023, 5, 5);
        run_one(2'd3, 2'd3, 2'd0, 2'd0, 1'b1, 6, 0, "R7 clamp state3");
        // R6 R7: negative target (666-741) -> 0, then floor 358>>7 = 2 / 358>>8 = 1
        run_one(2'd1, 2'd3, 2'd0, 2'd0, 1'b1, 2, 0, "R6 R7 negative fine");
        run_one(2'd1, 2'd3, 2'd0, 2'd0, 1'b0, 1, 0, "R6 R7 negative coarse");
        // R6: target 13282 saturates the grid
        set_cfg(4000, 0, 860, 1100, 4095, 1023, 1023, 1023);
        run_one(2'd3, 2'd1, 2'd1, 2'd1, 1'b1, 31, 0, "R6 saturate fine");
        run_one(2'd3, 2'd1, 2'd1, 2'd1, 1'b0, 15, 0, "R6 saturate coarse");

        // R8 R9: fill under stall, then release while a cell waits
        set_cfg(4000, 700, 860, 1100, 358, 82, 5, 5);
        @(negedge clk);
        o_ready = 1'b0;
        for (int i = 0; i < 3; i++) begin
            drive(VEC[i][14:13], VEC[i][8:7], VEC[i][10:9], VEC[i][12:11], VEC[i][6]);
            i_valid = 1'b1;
            @(negedge clk);
        end
        drive(VEC[3][14:13], VEC[3][8:7], VEC[3][10:9], VEC[3][12:11], VEC[3][6]);
        for (int i = 0; i < 3; i++) begin
            chk("R9 stalled valid", int'(o_valid), 1);
            chk("R9 stalled code", int'(o_code), 4);
            chk("R8 ready low in stall", int'(i_ready), 0);
            @(negedge clk);
        end
        o_ready = 1'b1;
        @(negedge clk);
        i_valid = 1'b0;
        chk("R8 order 2nd", int'(o_code), 2);
        @(negedge clk);
        chk("R8 order 3rd", int'(o_code), 6);
        @(negedge clk);
        chk("R8 order 4th", int'(o_code), 5);
        chk("R8 order 4th valid", int'(o_valid), 1);
        @(negedge clk);
        chk("R8 drained", int'(o_valid), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule